// File: doc/BRIEF.md
# Flash Modify Command Permission Checker

This block sits in front of a flash programming engine. It decides whether a modify command may run. The modify commands are write-page and erase-page. The decision depends on three things: the region the target address falls in, whether the issuing software is secure, and an unlock bit for that class of region. A granted command produces a one-cycle start pulse for the engine. A refused command produces a one-cycle reject pulse and raises a sticky lock-error flag. Software clears that flag by writing 1 to it. Commands of any other kind go straight through as granted, with no lock check.

The address map is fixed by parameters. The boot region and the application region of main flash each begin with a secure part. A non-secure-callable part is treated as secure. Data flash also begins with a secure part. A user row and a configuration row each have their own base address. The unlock registers come in two triads: one secure, one non-secure. Each triad has a boot bit, an application bit and a data bit. While reset is held, both triads load from configuration inputs. After reset they stay frozen.

Top module: `flash_modify_guard`

## Requirements
- R1: Each cycle with `cmd_valid` high gives, one clock later, exactly one of `cmd_start` or `cmd_reject` high for one cycle. A cycle without `cmd_valid` gives neither output in the next cycle.
- R2: A modify command (`cmd_op` 3'b001 write-page or 3'b010 erase-page) from a non-secure issuer (`cmd_secure`=0) is rejected for the following targets: the secure boot part, the secure application part, secure data flash, the user row and the configuration row.
- R3: A modify command from a secure issuer to a secure part is granted only if the matching secure unlock bit is 1. The bits are: bit 0 for boot, bit 1 for application, bit 2 for data.
- R4: A modify command to a non-secure boot, application or data part is granted only if the matching non-secure unlock bit is 1. The bit order is the same as in R3. This holds for either issuer.
- R5: A modify command to the user row is granted only if the issuer is secure and `urow_wr_en` is 1.
- R6: A modify command to the configuration row is granted only if the issuer is secure and `crow_wr_en` is 1.
- R7: A modify command to an address outside every mapped region is rejected.
- R8: A command with any other `cmd_op` value is granted, whatever the address, the issuer and the unlock state.
- R9: `lock_err` rises in the same cycle as `cmd_reject`. It stays high until a cycle with `err_clr`=1. If a new rejection is decided in that same cycle, the rejection wins and the flag stays set.
- R10: The unlock registers copy `cfg_sec_unlock` and `cfg_ns_unlock` while `rst_n` is low. After reset, changes on those inputs have no effect on decisions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code: 001 write-page, 010 erase-page, others pass |
| cmd_addr | input | ADDR_W | Target byte address |
| cmd_secure | input | 1 | Issuer is secure |
| cfg_sec_unlock | input | 3 | Reset defaults of the secure unlock bits (boot, app, data = bits 0..2) |
| cfg_ns_unlock | input | 3 | Reset defaults of the non-secure unlock bits (same order) |
| urow_wr_en | input | 1 | User row write-enable configuration bit |
| crow_wr_en | input | 1 | Configuration row write-enable configuration bit |
| err_clr | input | 1 | Write-1 clear of the lock-error flag |
| cmd_start | output | 1 | One-cycle grant pulse |
| cmd_reject | output | 1 | One-cycle refusal pulse |
| lock_err | output | 1 | Sticky lock-error flag |

## Verification
Two functions can fall in the same cycle: a rejection that sets the sticky flag, and the software clear. The bench provokes this by asserting `err_clr` in the same cycle as a locked modify command. It also asserts `err_clr` alongside a granted command and alongside an idle cycle. The behavioural model applies set-over-clear, and the flag is compared every clock. This catches both a clear that wins and a set that is lost.

// File: rtl/flash_guard_pkg.sv
// Package: shared command codes and region classes for the modify guard.
// Assumes a 3-bit command code; only write-page and erase-page are checked.
package flash_guard_pkg;

    typedef enum logic [2:0] {
        OP_WRITE_PAGE = 3'b001,
        OP_ERASE_PAGE = 3'b010
    } guard_op_e;

    typedef enum logic [3:0] {
        RC_BOOT_SEC,
        RC_BOOT_NS,
        RC_APP_SEC,
        RC_APP_NS,
        RC_DATA_SEC,
        RC_DATA_NS,
        RC_USER_ROW,
        RC_CFG_ROW,
        RC_UNMAPPED
    } region_cls_e;

    localparam int UNLOCK_BITS = 3;
    localparam int UL_BOOT     = 0;
    localparam int UL_APP      = 1;
    localparam int UL_DATA     = 2;

endpackage

// File: rtl/flash_region_decode.sv
// Region decoder: maps a byte address onto a region class.
// Assumes that each secure part sits at the low end of its region and that
// callable parts are covered by the secure part.
module flash_region_decode
    import flash_guard_pkg::*;
#(
    parameter int ADDR_W        = 24,
    parameter int ROW_BYTES     = 256,
    parameter int FLASH_ROWS    = 256,
    parameter int BOOT_ROWS     = 32,
    parameter int BOOT_SEC_ROWS = 8,
    parameter int APP_SEC_ROWS  = 64,
    parameter int DATA_BASE     = 'h40_0000,
    parameter int DATA_ROWS     = 8,
    parameter int DATA_SEC_ROWS = 2,
    parameter int UROW_BASE     = 'h80_4000,
    parameter int CROW_BASE     = 'h80_C000
) (
    input  logic [ADDR_W-1:0] addr,
    output region_cls_e       cls
);
    localparam logic [ADDR_W-1:0] BootSecEnd = ADDR_W'(BOOT_SEC_ROWS * ROW_BYTES);
    localparam logic [ADDR_W-1:0] BootEnd    = ADDR_W'(BOOT_ROWS * ROW_BYTES);
    localparam logic [ADDR_W-1:0] AppSecEnd  = ADDR_W'((BOOT_ROWS + APP_SEC_ROWS) * ROW_BYTES);
    localparam logic [ADDR_W-1:0] FlashEnd   = ADDR_W'(FLASH_ROWS * ROW_BYTES);
    localparam logic [ADDR_W-1:0] DataLo     = ADDR_W'(DATA_BASE);
    localparam logic [ADDR_W-1:0] DataSecEnd = ADDR_W'(DATA_BASE + DATA_SEC_ROWS * ROW_BYTES);
    localparam logic [ADDR_W-1:0] DataEnd    = ADDR_W'(DATA_BASE + DATA_ROWS * ROW_BYTES);
    localparam logic [ADDR_W-1:0] UrowLo     = ADDR_W'(UROW_BASE);
    localparam logic [ADDR_W-1:0] UrowEnd    = ADDR_W'(UROW_BASE + ROW_BYTES);
    localparam logic [ADDR_W-1:0] CrowLo     = ADDR_W'(CROW_BASE);
    localparam logic [ADDR_W-1:0] CrowEnd    = ADDR_W'(CROW_BASE + ROW_BYTES);

    // Purpose: classify the address by range compares, lowest region first.
    always_comb begin
        cls = RC_UNMAPPED;
        if (addr < BootSecEnd)                         cls = RC_BOOT_SEC;
        else if (addr < BootEnd)                       cls = RC_BOOT_NS;
        else if (addr < AppSecEnd)                     cls = RC_APP_SEC;
        else if (addr < FlashEnd)                      cls = RC_APP_NS;
        else if (addr >= DataLo && addr < DataSecEnd)  cls = RC_DATA_SEC;
        else if (addr >= DataSecEnd && addr < DataEnd) cls = RC_DATA_NS;
        else if (addr >= UrowLo && addr < UrowEnd)     cls = RC_USER_ROW;
        else if (addr >= CrowLo && addr < CrowEnd)     cls = RC_CFG_ROW;
    end

endmodule

// File: rtl/flash_modify_policy.sv
// Permission policy: combines region class, issuer security and unlock bits
// into a grant decision. Purely combinational; non-modify codes always pass.
module flash_modify_policy
    import flash_guard_pkg::*;
(
    input  logic [2:0]             op,
    input  region_cls_e            cls,
    input  logic                   secure,
    input  logic [UNLOCK_BITS-1:0] sec_ul,
    input  logic [UNLOCK_BITS-1:0] ns_ul,
    input  logic                   urow_wen,
    input  logic                   crow_wen,
    output logic                   allow
);
    logic is_modify;

    // Purpose: detect the two command codes that need a lock check.
    always_comb begin
        is_modify = (op == OP_WRITE_PAGE) || (op == OP_ERASE_PAGE);
    end

    // Purpose: per-class permission table.
    always_comb begin
        if (!is_modify) begin
            allow = 1'b1;
        end else begin
            unique case (cls)
                RC_BOOT_SEC: allow = secure & sec_ul[UL_BOOT];
                RC_BOOT_NS:  allow = ns_ul[UL_BOOT];
                RC_APP_SEC:  allow = secure & sec_ul[UL_APP];
                RC_APP_NS:   allow = ns_ul[UL_APP];
                RC_DATA_SEC: allow = secure & sec_ul[UL_DATA];
                RC_DATA_NS:  allow = ns_ul[UL_DATA];
                RC_USER_ROW: allow = secure & urow_wen;
                RC_CFG_ROW:  allow = secure & crow_wen;
                default:     allow = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/flash_unlock_regs.sv
// Unlock register bank: while reset is held, each bank follows its
// configuration default; outside reset it holds its value.
module flash_unlock_regs #(
    parameter int BANKS = 2,
    parameter int WIDTH = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [BANKS-1:0][WIDTH-1:0] dflt,
    output logic [BANKS-1:0][WIDTH-1:0] q
);
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        // Purpose: capture the default of bank b during reset, hold afterwards.
        always_ff @(posedge clk) begin
            if (!rst_n) q[b] <= dflt[b];
        end
    end

endmodule

// File: rtl/flash_modify_guard.sv
// Top: registers the grant/reject decision for each command and keeps the
// sticky lock-error flag. Assumes one command per cycle at most and that
// the configuration defaults are stable while reset is held.
module flash_modify_guard
    import flash_guard_pkg::*;
#(
    parameter int ADDR_W        = 24,
    parameter int ROW_BYTES     = 256,
    parameter int FLASH_ROWS    = 256,
    parameter int BOOT_ROWS     = 32,
    parameter int BOOT_SEC_ROWS = 8,
    parameter int APP_SEC_ROWS  = 64,
    parameter int DATA_BASE     = 'h40_0000,
    parameter int DATA_ROWS     = 8,
    parameter int DATA_SEC_ROWS = 2,
    parameter int UROW_BASE     = 'h80_4000,
    parameter int CROW_BASE     = 'h80_C000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_secure,
    input  logic [2:0]        cfg_sec_unlock,
    input  logic [2:0]        cfg_ns_unlock,
    input  logic              urow_wr_en,
    input  logic              crow_wr_en,
    input  logic              err_clr,
    output logic              cmd_start,
    output logic              cmd_reject,
    output logic              lock_err
);
    region_cls_e                        cls;
    logic                               allow;
    logic [1:0][UNLOCK_BITS-1:0]        ul_dflt;
    logic [1:0][UNLOCK_BITS-1:0]        ul_q;
    logic [UNLOCK_BITS-1:0]             sec_ul_q;
    logic [UNLOCK_BITS-1:0]             ns_ul_q;
    logic                               deny;

    // Purpose: pack the configuration defaults and unpack the held banks.
    always_comb begin
        ul_dflt[0] = cfg_sec_unlock;
        ul_dflt[1] = cfg_ns_unlock;
        sec_ul_q   = ul_q[0];
        ns_ul_q    = ul_q[1];
        deny       = cmd_valid & ~allow;
    end

    flash_unlock_regs #(.BANKS(2), .WIDTH(UNLOCK_BITS)) u_unlock (
        .clk   (clk),
        .rst_n (rst_n),
        .dflt  (ul_dflt),
        .q     (ul_q)
    );

    flash_region_decode #(
        .ADDR_W(ADDR_W), .ROW_BYTES(ROW_BYTES), .FLASH_ROWS(FLASH_ROWS),
        .BOOT_ROWS(BOOT_ROWS), .BOOT_SEC_ROWS(BOOT_SEC_ROWS),
        .APP_SEC_ROWS(APP_SEC_ROWS), .DATA_BASE(DATA_BASE),
        .DATA_ROWS(DATA_ROWS), .DATA_SEC_ROWS(DATA_SEC_ROWS),
        .UROW_BASE(UROW_BASE), .CROW_BASE(CROW_BASE)
    ) u_decode (
        .addr (cmd_addr),
        .cls  (cls)
    );

    flash_modify_policy u_policy (
        .op       (cmd_op),
        .cls      (cls),
        .secure   (cmd_secure),
        .sec_ul   (sec_ul_q),
        .ns_ul    (ns_ul_q),
        .urow_wen (urow_wr_en),
        .crow_wen (crow_wr_en),
        .allow    (allow)
    );

    // Purpose: one-cycle decision pulses and the set-over-clear error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_start  <= 1'b0;
            cmd_reject <= 1'b0;
            lock_err   <= 1'b0;
        end else begin
            cmd_start  <= cmd_valid & allow;
            cmd_reject <= deny;
            lock_err   <= (lock_err & ~err_clr) | deny;
        end
    end

endmodule

// File: rtl/flash_modify_guard_chk.sv
// Checker: temporal properties of the modify guard, bound to the top.
module flash_modify_guard_chk #(
    parameter int ADDR_W        = 24,
    parameter int ROW_BYTES     = 256,
    parameter int BOOT_SEC_ROWS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              cmd_secure,
    input logic              err_clr,
    input logic              cmd_start,
    input logic              cmd_reject,
    input logic              lock_err,
    input logic [2:0]        sec_ul_q,
    input logic [2:0]        ns_ul_q
);
    localparam logic [ADDR_W-1:0] BootSecEnd = ADDR_W'(BOOT_SEC_ROWS * ROW_BYTES);
    logic modify_op;
    logic past_run;
    always_comb modify_op = (cmd_op == 3'b001) || (cmd_op == 3'b010);

    // Purpose: remember that at least one cycle has passed outside reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_run <= 1'b0;
        else        past_run <= 1'b1;
    end

    AST_ONE_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> $onehot({cmd_start, cmd_reject})); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !cmd_start && !cmd_reject); // R1
    AST_NS_SEC_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && modify_op && !cmd_secure && cmd_addr < BootSecEnd |=> cmd_reject); // R2
    AST_OTHER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !modify_op |=> cmd_start); // R8
    AST_REJECT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reject |-> lock_err); // R9
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        lock_err && !err_clr |=> lock_err); // R9
    AST_CLEAR_UNLESS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr |=> lock_err == cmd_reject); // R9
    AST_UNLOCK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        past_run |-> $stable(sec_ul_q) && $stable(ns_ul_q)); // R10

endmodule

bind flash_modify_guard flash_modify_guard_chk #(
    .ADDR_W(ADDR_W), .ROW_BYTES(ROW_BYTES), .BOOT_SEC_ROWS(BOOT_SEC_ROWS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_addr   (cmd_addr),
    .cmd_secure (cmd_secure),
    .err_clr    (err_clr),
    .cmd_start  (cmd_start),
    .cmd_reject (cmd_reject),
    .lock_err   (lock_err),
    .sec_ul_q   (sec_ul_q),
    .ns_ul_q    (ns_ul_q)
);

// File: tb/tb_flash_modify_guard.sv
// Bench: behavioural reference model updated at each rising edge and
// compared with the outputs at each falling edge.
module tb_flash_modify_guard;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = 3'd0;
    logic [AW-1:0] cmd_addr = '0;
    logic          cmd_secure = 1'b0;
    logic [2:0]    cfg_sec_unlock = 3'b101;
    logic [2:0]    cfg_ns_unlock = 3'b011;
    logic          urow_wr_en = 1'b0;
    logic          crow_wr_en = 1'b0;
    logic          err_clr = 1'b0;
    logic          cmd_start, cmd_reject, lock_err;

    int n_checks = 0;
    int n_fail = 0;

    flash_modify_guard dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_secure(cmd_secure),
        .cfg_sec_unlock(cfg_sec_unlock), .cfg_ns_unlock(cfg_ns_unlock),
        .urow_wr_en(urow_wr_en), .crow_wr_en(crow_wr_en), .err_clr(err_clr),
        .cmd_start(cmd_start), .cmd_reject(cmd_reject), .lock_err(lock_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model state
    bit    m_start, m_rej, m_err;
    bit [2:0] m_sul, m_nsul;
    string m_tag = "reset";

    // Permission by plain address arithmetic on the default map.
    function automatic bit permit(input int op, input int a, input bit s,
                                  input bit [2:0] sul, input bit [2:0] nsul,
                                  input bit uw, input bit cw, output string tag);
        if (op != 1 && op != 2) begin tag = "R8"; return 1; end
        if (a < 'h800)   begin tag = s ? "R3 boot" : "R2 boot"; return s && sul[0]; end
        if (a < 'h2000)  begin tag = "R4 boot"; return nsul[0]; end
        if (a < 'h6000)  begin tag = s ? "R3 app" : "R2 app"; return s && sul[1]; end
        if (a < 'h10000) begin tag = "R4 app"; return nsul[1]; end
        if (a >= 'h400000 && a < 'h400200) begin tag = s ? "R3 data" : "R2 data"; return s && sul[2]; end
        if (a >= 'h400200 && a < 'h400800) begin tag = "R4 data"; return nsul[2]; end
        if (a >= 'h804000 && a < 'h804100) begin tag = s ? "R5" : "R2 urow"; return s && uw; end
        if (a >= 'h80C000 && a < 'h80C100) begin tag = s ? "R6" : "R2 crow"; return s && cw; end
        tag = "R7";
        return 0;
    endfunction

    // Model update at the active edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_start = 0; m_rej = 0; m_err = 0;
            m_sul = cfg_sec_unlock; m_nsul = cfg_ns_unlock;
            m_tag = "reset";
        end else begin
            bit ok;
            string t;
            ok = 1;
            t = "R1 idle";
            if (cmd_valid)
                ok = permit(int'(cmd_op), int'(cmd_addr), cmd_secure, m_sul, m_nsul,
                            urow_wr_en, crow_wr_en, t);
            if (cfg_sec_unlock != m_sul || cfg_ns_unlock != m_nsul) t = {"R10 ", t};
            m_start = cmd_valid && ok;
            m_rej   = cmd_valid && !ok;
            m_err   = (m_err && !err_clr) || m_rej;
            m_tag   = err_clr ? {t, " R9 clear"} : t;
        end
    end

    // Compare away from the edge
    always @(negedge clk) begin
        n_checks++;
        if (cmd_start !== m_start || cmd_reject !== m_rej) begin
            n_fail++;
            $display("FAIL %s (R1): start/reject=%b%b expected %b%b at %0t",
                     m_tag, cmd_start, cmd_reject, m_start, m_rej, $time);
        end
        n_checks++;
        if (lock_err !== m_err) begin
            n_fail++;
            $display("FAIL R9 %s: lock_err=%b expected %b at %0t",
                     m_tag, lock_err, m_err, $time);
        end
    end

    task automatic cyc(input bit v, input int op, input int a, input bit s, input bit clr);
        @(negedge clk);
        cmd_valid = v; cmd_op = 3'(op); cmd_addr = AW'(a); cmd_secure = s; err_clr = clr;
    endtask

    function automatic int region_addr(input int i);
        case (i)
            0: return 'h000100;  1: return 'h002100;  2: return 'h003000;
            3: return 'h008000;  4: return 'h400080;  5: return 'h400400;
            6: return 'h804010;  7: return 'h80C020;  default: return 'h020000;
        endcase
    endfunction

    task automatic sweep();
        for (int i = 0; i < 9; i++)
            for (int s = 0; s < 2; s++)
                for (int op = 1; op < 4; op++)
                    cyc(1, op, region_addr(i), s[0], 0);
        cyc(0, 0, 0, 0, 0);
    endtask

    task automatic do_reset(input bit [2:0] su, input bit [2:0] nu);
        @(negedge clk);
        rst_n = 0; cfg_sec_unlock = su; cfg_ns_unlock = nu; cmd_valid = 0; err_clr = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        do_reset(3'b101, 3'b011);
        // Main sweep with row enables off, then on
        sweep();
        urow_wr_en = 1; crow_wr_en = 1;
        sweep();
        // R9: clear alone, clear with a rejection, clear with a grant
        cyc(1, 1, region_addr(8), 1, 0);
        cyc(0, 0, 0, 0, 1);
        cyc(1, 2, region_addr(8), 0, 0);
        cyc(1, 1, region_addr(8), 1, 1);
        cyc(1, 1, region_addr(3), 1, 1);
        cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 1);
        // R10: change defaults after reset, behaviour must not move
        cfg_sec_unlock = 3'b010; cfg_ns_unlock = 3'b100;
        sweep();
        // New reset picks up the new defaults
        do_reset(3'b010, 3'b100);
        urow_wr_en = 0; crow_wr_en = 1;
        sweep();
        do_reset(3'b111, 3'b111);
        sweep();
        do_reset(3'b000, 3'b000);
        sweep();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule